// File: doc/BRIEF.md
# Set/Clear Interrupt Controller with Two-Way Routing

This block collects sixteen interrupt sources for a small microcontroller and delivers them to two destinations: an interrupt line toward the host and an interrupt line toward the local core. Each source can be raised by a hardware line or by software. Its pending state, its enable and its trigger style are changed through separate write-one-to-set and write-one-to-clear addresses, so software never needs a read-modify-write sequence.

Source positions are fixed. Bit 0 is the general-purpose timer, bit 1 the watchdog, bit 2 the method interface, bit 3 the context switch and bit 4 the halt. Bit 5 is the external error, bits 6 and 7 are the two software-generated sources, and bits 8 to 15 are external sources. A 32-bit routing word picks the destinations. The lower half enables host delivery and the upper half enables local delivery, so one source may go to both outputs, to one of them, or to neither. A one-bit host summary shows the combined host-bound interrupt, and a separate one-bit host enable gates it onto the host pin.

The register bus is a simple 32-bit word-addressed port. A write takes effect at the clock edge where `bus_wr_en` is sampled high. A read captures the addressed value at the clock edge where `bus_rd_en` is sampled high and presents it on `bus_rdata` after that edge.

Top module: `sc_irq_ctrl`

## Requirements
- R1: After reset, the following all read as zero: the status word (address 0x0), the enable word (0x3), the mode word (0x6), the routing word (0x9), the host summary (0xA) and the host enable (0xB). Both interrupt outputs are low after reset.
- R2: Writing to address 0x1 sets every status bit that is 1 in the data. Writing to address 0x2 clears every status bit that is 1 in the data. Bits that are 0 in either write leave status unchanged. Status reads back at address 0x0 one clock after the write.
- R3: In edge mode (mode bit 0), a rising edge on a source line sets that status bit. The bit stays set after the line falls, until software clears it.
- R4: In level mode (mode bit 1), the status bit is the OR of the registered source line and any software-set value. When the line falls, the status bit drops unless software has set it.
- R5: Writing to address 0x4 sets enable bits and writing to address 0x5 clears them, with 0 bits having no effect. The current enable word reads at address 0x3.
- R6: Writing to address 0x7 sets mode bits and writing to address 0x8 clears them, with 0 bits having no effect. The current mode word reads at address 0x6, where 1 means level and 0 means edge.
- R7: The routing word at address 0x9 is read-write. Bit i (0-15) enables host delivery of source i, and bit 16+i enables local delivery of source i.
- R8: The local output is high exactly when some source has its status set, its enable set and its local routing bit set.
- R9: Bit 0 of address 0xA reads as the OR over sources of status, enable and host routing. Bit 0 of address 0xB is a read-write host enable. The host output equals the summary ANDed with that enable.
- R10: When a rising edge and a status-clear write reach the same edge-mode source in the same clock, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 16 | Raw hardware interrupt lines, one per source |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the clock that sampled the read strobe |
| irq_host_o | output | 1 | Interrupt toward the host |
| irq_local_o | output | 1 | Interrupt toward the local core |

## Verification
The hardest case to reach from the ports is the collision between a hardware rising edge and a software clear on the same source within a single clock. To create it, the stimulus first sets that status bit by software. It then raises the source line and issues the clear write at the same falling edge, so both are sampled by the same rising edge. A follow-up clear, issued while the line is held high and no new edge occurs, shows that the earlier survival came from the edge and not from a clear that failed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Register word addresses. Each set/clear pair is placed next to
   // the read address of the word it changes.
   typedef enum logic [3:0] {
      REG_STAT      = 4'h0,
      REG_STAT_SET  = 4'h1,
      REG_STAT_CLR  = 4'h2,
      REG_EN        = 4'h3,
      REG_EN_SET    = 4'h4,
      REG_EN_CLR    = 4'h5,
      REG_MODE      = 4'h6,
      REG_MODE_SET  = 4'h7,
      REG_MODE_CLR  = 4'h8,
      REG_ROUTE     = 4'h9,
      REG_HOST_SUM  = 4'hA,
      REG_HOST_EN   = 4'hB
   } irqc_reg_e;

   localparam int REG_SEL_W = 4;

   // Fixed source positions.
   localparam int SRC_GPTIMER  = 0;
   localparam int SRC_WATCHDOG = 1;
   localparam int SRC_METHOD   = 2;
   localparam int SRC_CTXSW    = 3;
   localparam int SRC_HALT     = 4;
   localparam int SRC_EXTERR   = 5;
   localparam int SRC_SWGEN0   = 6;
   localparam int SRC_SWGEN1   = 7;
   localparam int SRC_EXT_BASE = 8;

endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_in,
   input  logic sw_set,
   input  logic sw_clr,
   input  logic level_mode,
   output logic stat_o
);

   logic prev_q;
   logic latch_q;
   logic rise;

   assign rise = irq_in & ~prev_q;

   // The latch holds software-set state, and in edge mode it also holds
   // captured edges. The OR comes after the clear, so an edge in the
   // same clock as a clear survives it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= irq_in;
         latch_q <= (latch_q & ~sw_clr) | sw_set | (rise & ~level_mode);
      end
   end

   assign stat_o = latch_q | (prev_q & level_mode);

   AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && irq_in && !prev_q) |=> stat_o);  // R3

   AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && irq_in && !prev_q && sw_clr) |=> stat_o);  // R10

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr && !sw_set && !irq_in) |=> !stat_o);  // R2

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr_en,
   input  logic                 bus_rd_en,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_SRC-1:0]   stat_i,
   input  logic                 host_sum_i,
   output logic [NUM_SRC-1:0]   stat_set_o,
   output logic [NUM_SRC-1:0]   stat_clr_o,
   output logic [NUM_SRC-1:0]   en_o,
   output logic [NUM_SRC-1:0]   mode_o,
   output logic [2*NUM_SRC-1:0] route_o,
   output logic                 host_en_o
);

   localparam int ROUTE_W = 2 * NUM_SRC;

   logic                 addr_ok;
   irqc_reg_e            sel;
   logic                 wr_hit;
   logic [NUM_SRC-1:0]   en_set;
   logic [NUM_SRC-1:0]   en_clr;
   logic [NUM_SRC-1:0]   mode_set;
   logic [NUM_SRC-1:0]   mode_clr;
   logic                 route_wr;
   logic                 host_en_wr;
   logic [NUM_SRC-1:0]   en_q;
   logic [NUM_SRC-1:0]   mode_q;
   logic [ROUTE_W-1:0]   route_q;
   logic                 host_en_q;
   logic [DATA_W-1:0]    rd_next;
   logic [DATA_W-1:0]    rdata_q;

   generate
      if (ADDR_W > REG_SEL_W) begin : g_wide_addr
         assign addr_ok = (bus_addr[ADDR_W-1:REG_SEL_W] == '0);
      end else begin : g_exact_addr
         assign addr_ok = 1'b1;
      end
   endgenerate

   assign sel    = irqc_reg_e'(bus_addr[REG_SEL_W-1:0]);
   assign wr_hit = bus_wr_en & addr_ok;

   always_comb begin
      stat_set_o = '0;
      stat_clr_o = '0;
      en_set     = '0;
      en_clr     = '0;
      mode_set   = '0;
      mode_clr   = '0;
      route_wr   = 1'b0;
      host_en_wr = 1'b0;
      if (wr_hit) begin
         case (sel)
            REG_STAT_SET: stat_set_o = bus_wdata[NUM_SRC-1:0];
            REG_STAT_CLR: stat_clr_o = bus_wdata[NUM_SRC-1:0];
            REG_EN_SET:   en_set     = bus_wdata[NUM_SRC-1:0];
            REG_EN_CLR:   en_clr     = bus_wdata[NUM_SRC-1:0];
            REG_MODE_SET: mode_set   = bus_wdata[NUM_SRC-1:0];
            REG_MODE_CLR: mode_clr   = bus_wdata[NUM_SRC-1:0];
            REG_ROUTE:    route_wr   = 1'b1;
            REG_HOST_EN:  host_en_wr = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= '0;
         mode_q    <= '0;
         route_q   <= '0;
         host_en_q <= 1'b0;
      end else begin
         en_q   <= (en_q | en_set) & ~en_clr;
         mode_q <= (mode_q | mode_set) & ~mode_clr;
         if (route_wr)   route_q   <= bus_wdata[ROUTE_W-1:0];
         if (host_en_wr) host_en_q <= bus_wdata[0];
      end
   end

   // Set and clear addresses read back as zero.
   always_comb begin
      rd_next = '0;
      if (addr_ok) begin
         case (sel)
            REG_STAT:     rd_next[NUM_SRC-1:0] = stat_i;
            REG_EN:       rd_next[NUM_SRC-1:0] = en_q;
            REG_MODE:     rd_next[NUM_SRC-1:0] = mode_q;
            REG_ROUTE:    rd_next[ROUTE_W-1:0] = route_q;
            REG_HOST_SUM: rd_next[0]           = host_sum_i;
            REG_HOST_EN:  rd_next[0]           = host_en_q;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata_q <= '0;
      else if (bus_rd_en) rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;
   assign en_o      = en_q;
   assign mode_o    = mode_q;
   assign route_o   = route_q;
   assign host_en_o = host_en_q;

   AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && sel == REG_EN_SET) |=>
      ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));  // R5

   AST_MODE_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && sel == REG_MODE_CLR) |=>
      ((mode_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));  // R6

   AST_ROUTE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && sel == REG_ROUTE) |=> (route_q == $past(bus_wdata[ROUTE_W-1:0])));  // R7

endmodule

// File: rtl/irqc_deliver.sv
module irqc_deliver #(
   parameter int NUM_SRC = 16
) (
   input  logic [NUM_SRC-1:0]   stat_i,
   input  logic [NUM_SRC-1:0]   en_i,
   input  logic [2*NUM_SRC-1:0] route_i,
   input  logic                 host_en_i,
   output logic                 host_sum_o,
   output logic                 irq_host_o,
   output logic                 irq_local_o
);

   logic [NUM_SRC-1:0] live;

   assign live        = stat_i & en_i;
   assign host_sum_o  = |(live & route_i[NUM_SRC-1:0]);
   assign irq_local_o = |(live & route_i[2*NUM_SRC-1:NUM_SRC]);
   assign irq_host_o  = host_sum_o & host_en_i;

endmodule

// File: rtl/sc_irq_ctrl.sv
module sc_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src_i,
   input  logic               bus_wr_en,
   input  logic               bus_rd_en,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_host_o,
   output logic               irq_local_o
);

   localparam int ROUTE_W = 2 * NUM_SRC;

   generate
      if (NUM_SRC < SRC_EXT_BASE) begin : g_bad_src
         initial $fatal(1, "NUM_SRC must cover the fixed source positions");
      end
      if (ROUTE_W > DATA_W) begin : g_bad_data
         initial $fatal(1, "routing word does not fit the data bus");
      end
      if (ADDR_W < REG_SEL_W) begin : g_bad_addr
         initial $fatal(1, "address too narrow for the register map");
      end
   endgenerate

   logic [NUM_SRC-1:0] stat;
   logic [NUM_SRC-1:0] stat_set;
   logic [NUM_SRC-1:0] stat_clr;
   logic [NUM_SRC-1:0] en;
   logic [NUM_SRC-1:0] mode;
   logic [ROUTE_W-1:0] route;
   logic               host_en;
   logic               host_sum;

   irqc_regfile #(
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr_en  (bus_wr_en),
      .bus_rd_en  (bus_rd_en),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .stat_i     (stat),
      .host_sum_i (host_sum),
      .stat_set_o (stat_set),
      .stat_clr_o (stat_clr),
      .en_o       (en),
      .mode_o     (mode),
      .route_o    (route),
      .host_en_o  (host_en)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      irqc_src_cell u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .irq_in     (irq_src_i[i]),
         .sw_set     (stat_set[i]),
         .sw_clr     (stat_clr[i]),
         .level_mode (mode[i]),
         .stat_o     (stat[i])
      );
   end

   irqc_deliver #(.NUM_SRC(NUM_SRC)) u_dlv (
      .stat_i      (stat),
      .en_i        (en),
      .route_i     (route),
      .host_en_i   (host_en),
      .host_sum_o  (host_sum),
      .irq_host_o  (irq_host_o),
      .irq_local_o (irq_local_o)
   );

   AST_LOCAL_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      irq_local_o |-> ((stat & en & route[ROUTE_W-1:NUM_SRC]) != '0));  // R8

   AST_HOST_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      irq_host_o |-> (host_en && ((stat & en & route[NUM_SRC-1:0]) != '0)));  // R9

endmodule

// File: tb/tb_sc_irq_ctrl.sv
`timescale 1ns/1ps
module tb_sc_irq_ctrl;

   localparam logic [3:0] A_STAT = 4'h0, A_SSET = 4'h1, A_SCLR = 4'h2,
                          A_EN = 4'h3, A_ESET = 4'h4, A_ECLR = 4'h5,
                          A_MODE = 4'h6, A_MSET = 4'h7, A_MCLR = 4'h8,
                          A_ROUTE = 4'h9, A_HSUM = 4'hA, A_HEN = 4'hB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_src_i = '0;
   logic        bus_wr_en = 1'b0;
   logic        bus_rd_en = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_host_o;
   logic        irq_local_o;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #2 clk = ~clk;

   sc_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i),
      .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_host_o(irq_host_o), .irq_local_o(irq_local_o)
   );

   // Monitor: a read sampled at a rising edge is compared at the next falling edge.
   always @(posedge clk) rd_seen <= bus_rd_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL scoreboard: read with no expectation, actual %h", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (bus_rdata !== e) begin
               mismatched++;
               $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(t);
      bus_rd_en = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   task automatic chk_pin(input logic act, input logic e, input string t);
      compared++;
      if (act !== e) begin
         mismatched++;
         $display("FAIL %s: pin actual %b expected %b", t, act, e);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_STAT, 32'h0, "R1 status");
      rd(A_EN, 32'h0, "R1 enable");
      rd(A_MODE, 32'h0, "R1 mode");
      rd(A_ROUTE, 32'h0, "R1 route");
      rd(A_HSUM, 32'h0, "R1 host summary");
      rd(A_HEN, 32'h0, "R1 host enable");
      chk_pin(irq_host_o, 1'b0, "R1 host pin");
      chk_pin(irq_local_o, 1'b0, "R1 local pin");

      // R2 set/clear of status
      wr(A_SSET, 32'h0000_00C1);
      rd(A_STAT, 32'h0000_00C1, "R2 set");
      wr(A_SSET, 32'h0);
      rd(A_STAT, 32'h0000_00C1, "R2 zero set no effect");
      wr(A_SCLR, 32'h0000_0041);
      rd(A_STAT, 32'h0000_0080, "R2 clear");
      wr(A_SCLR, 32'h0);
      rd(A_STAT, 32'h0000_0080, "R2 zero clear no effect");
      wr(A_SCLR, 32'hFFFF);

      // R3 edge capture is sticky
      @(negedge clk); irq_src_i[9] = 1'b1;
      @(negedge clk); irq_src_i[9] = 1'b0;
      rd(A_STAT, 32'h0000_0200, "R3 edge sticky");
      wr(A_SCLR, 32'h0000_0200);
      rd(A_STAT, 32'h0, "R3 cleared");

      // R6 mode, R4 level following
      wr(A_MSET, 32'h0000_0010);
      rd(A_MODE, 32'h0000_0010, "R6 mode set");
      @(negedge clk); irq_src_i[4] = 1'b1;
      rd(A_STAT, 32'h0000_0010, "R4 level high");
      @(negedge clk); irq_src_i[4] = 1'b0;
      rd(A_STAT, 32'h0, "R4 level drop");
      wr(A_SSET, 32'h0000_0010);
      rd(A_STAT, 32'h0000_0010, "R4 software value in level");
      wr(A_SCLR, 32'h0000_0010);
      wr(A_MCLR, 32'h0000_0010);
      rd(A_MODE, 32'h0, "R6 mode clear");

      // R5 enable
      wr(A_ESET, 32'h0000_0F0F);
      wr(A_ECLR, 32'h0000_0303);
      rd(A_EN, 32'h0000_0C0C, "R5 enable set/clear");

      // R7 routing: source 3 to host, source 2 to local
      wr(A_ROUTE, 32'h0004_0008);
      rd(A_ROUTE, 32'h0004_0008, "R7 route readback");

      // R8 / R9 delivery
      wr(A_SSET, 32'h0000_0004);
      chk_pin(irq_local_o, 1'b1, "R8 local asserted");
      chk_pin(irq_host_o, 1'b0, "R8 host stays low");
      rd(A_HSUM, 32'h0, "R9 summary low for local-only source");
      wr(A_SSET, 32'h0000_0008);
      rd(A_HSUM, 32'h1, "R9 summary high");
      chk_pin(irq_host_o, 1'b0, "R9 host gated by host enable");
      wr(A_HEN, 32'h1);
      rd(A_HEN, 32'h1, "R9 host enable readback");
      chk_pin(irq_host_o, 1'b1, "R9 host asserted");
      wr(A_ECLR, 32'h0000_0008);
      chk_pin(irq_host_o, 1'b0, "R9 host drops when disabled");
      rd(A_HSUM, 32'h0, "R9 summary drops");
      wr(A_ECLR, 32'h0000_0004);
      chk_pin(irq_local_o, 1'b0, "R8 local drops when disabled");
      wr(A_SCLR, 32'hFFFF);

      // R10 edge and clear in the same clock
      wr(A_SSET, 32'h0000_1000);
      @(negedge clk);
      irq_src_i[12] = 1'b1;
      bus_wr_en = 1'b1; bus_addr = A_SCLR; bus_wdata = 32'h0000_1000;
      @(negedge clk);
      bus_wr_en = 1'b0;
      rd(A_STAT, 32'h0000_1000, "R10 edge wins over clear");
      wr(A_SCLR, 32'h0000_1000);
      rd(A_STAT, 32'h0, "R2 clear with line high and no edge");
      @(negedge clk); irq_src_i[12] = 1'b0;

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         mismatched++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      summary();
   end

endmodule